// File: doc/BRIEF.md
# Debug-Accessible Register with Hardware Breakpoint

This block wraps one architectural storage register of a generated processor core. On top of the normal write and read paths, it adds the hooks a debugger needs. A global run enable freezes the register while the core is halted. A separate debug write port can overwrite the contents at any time, and the stored value is always visible on a dedicated debug read output.

The block also watches its own functional write path for a hardware breakpoint. When a breakpoint is armed and a functional write lands, it raises a single-cycle hit that asks the core to enter debug mode. The trigger can be any landing write, or only a write whose data equals a programmed compare value.

A build-time parameter picks the flavour. The data flavour is used for ordinary user registers, and value matching is optional there. The program flavour is used for the program counter: the hit is raised when the PC is loaded with the programmed address. The hit therefore appears in the same cycle the register first holds that address, before the instruction there can change state. The breakpoint configuration is held in registers inside the block and is loaded through a strobe.

Top module: `dbg_reg_bp`

## Requirements
- R1: After reset, `rd_data`, `dbg_rd_data` and `bp_hit` are zero, and the breakpoint configuration is cleared (disarmed, value-sensitive off, compare value zero).
- R2: While `run_en` is 0, a functional write (`fn_we`=1) does not change the stored value.
- R3: A debug write (`dbg_we`=1) loads `dbg_wdata` at the next clock edge, whatever the value of `run_en`.
- R4: When `dbg_we` and an accepted functional write occur in the same cycle, the stored value becomes `dbg_wdata`.
- R5: `rd_data` and `dbg_rd_data` both show the stored value, which changes in the cycle after the edge at which the write was taken.
- R6: In the data flavour, with the breakpoint armed and value-sensitive off, every accepted functional write raises `bp_hit` in the cycle after the write.
- R7: In the data flavour, with value-sensitive on, a write raises `bp_hit` only if `fn_wdata` equals the compare value.
- R8: With the breakpoint disarmed, `bp_hit` stays 0.
- R9: `bp_hit` is raised only after an accepted functional write. A write is accepted when `fn_we`=1, `run_en`=1 and `dbg_we`=0, so no hit follows a blocked write or a debug write.
- R10: `bp_hit` is never high in two consecutive cycles. A detection in the cycle right after a hit is dropped.
- R11: In the program flavour, an armed breakpoint fires on an accepted write whose data equals the compare address, whatever the value-sensitive setting. The hit is high in the same cycle that `rd_data` first shows that address.
- R12: When `cfg_we`=1, the arm bit, the value-sensitive bit and the compare value are captured at that edge. They take effect for writes from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_en | input | 1 | Global run enable; 0 means the core is halted |
| fn_we | input | 1 | Functional write enable |
| fn_wdata | input | WIDTH | Functional write data |
| dbg_we | input | 1 | Debug write strobe |
| dbg_wdata | input | WIDTH | Debug write data |
| cfg_we | input | 1 | Breakpoint configuration load strobe |
| cfg_en | input | 1 | Breakpoint arm bit to load |
| cfg_vsens | input | 1 | Value-sensitive bit to load (data flavour only) |
| cfg_value | input | WIDTH | Compare value or address to load |
| rd_data | output | WIDTH | Functional read path |
| dbg_rd_data | output | WIDTH | Debug read path |
| bp_hit | output | 1 | Single-cycle breakpoint hit, request to enter debug mode |

## Verification
On every cycle, the embedded properties check the following:
- the register holds while halted;
- a debug write lands;
- a hit never lasts two cycles and never appears without an accepted write or while disarmed;
- a non-matching value-sensitive write yields no hit;
- an address match on the program flavour always hits.

Only the bench scenarios can show that the write path picks the right source for every mix of strobes. They also show that a newly loaded configuration governs the following writes rather than the current one, and that both flavours track a reference model over long random runs with repeated compare values.

// File: rtl/dbgreg_pkg.sv
package dbgreg_pkg;
  typedef enum logic {
    BP_DATA = 1'b0,
    BP_PROG = 1'b1
  } bp_kind_e;

  typedef struct packed {
    logic armed;
    logic vsens;
  } bp_ctl_t;
endpackage

// File: rtl/dbg_rst_sync.sv
module dbg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = chain_q[STAGES-1];
endmodule

// File: rtl/dbg_store.sv
module dbg_store #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             fn_we,
  input  logic [WIDTH-1:0] fn_wdata,
  input  logic             dbg_we,
  input  logic [WIDTH-1:0] dbg_wdata,
  output logic             fn_acc,
  output logic [WIDTH-1:0] value
);
  logic [WIDTH-1:0] val_q, val_nxt;
  logic             val_ld;

  // Functional write lands only while running and not overridden by debug
  assign fn_acc = fn_we & run_en & ~dbg_we;
  assign val_ld = dbg_we | fn_acc;

  always_comb begin
    val_nxt = val_q;
    if (dbg_we)      val_nxt = dbg_wdata;
    else if (fn_acc) val_nxt = fn_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_q <= '0;
    else if (val_ld) val_q <= val_nxt;
  end

  assign value = val_q;

  // R2
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !dbg_we) |=> $stable(value));

  // R3
  dbg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_we |=> (value == $past(dbg_wdata)));
endmodule

// File: rtl/dbg_bp_cfg.sv
module dbg_bp_cfg #(
  parameter int WIDTH = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic                cfg_en,
  input  logic                cfg_vsens,
  input  logic [WIDTH-1:0]    cfg_value,
  output dbgreg_pkg::bp_ctl_t ctl,
  output logic [WIDTH-1:0]    cmp
);
  dbgreg_pkg::bp_ctl_t ctl_q, ctl_nxt;
  logic [WIDTH-1:0]    cmp_q, cmp_nxt;

  always_comb begin
    ctl_nxt       = ctl_q;
    cmp_nxt       = cmp_q;
    if (cfg_we) begin
      ctl_nxt.armed = cfg_en;
      ctl_nxt.vsens = cfg_vsens;
      cmp_nxt       = cfg_value;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      cmp_q <= '0;
    end else if (cfg_we) begin
      ctl_q <= ctl_nxt;
      cmp_q <= cmp_nxt;
    end
  end

  assign ctl = ctl_q;
  assign cmp = cmp_q;

  // R12
  cfg_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (ctl.armed == $past(cfg_en) && cmp == $past(cfg_value)));
endmodule

// File: rtl/dbg_bp_detect.sv
module dbg_bp_detect #(
  parameter int                   WIDTH = 32,
  parameter dbgreg_pkg::bp_kind_e KIND  = dbgreg_pkg::BP_DATA
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_acc,
  input  logic [WIDTH-1:0]    wdata,
  input  dbgreg_pkg::bp_ctl_t ctl,
  input  logic [WIDTH-1:0]    cmp,
  output logic                hit
);
  logic eq, match, det, hit_q, hit_nxt;

  assign eq = (wdata == cmp);

  generate
    if (KIND == dbgreg_pkg::BP_PROG) begin : g_prog
      // Address breakpoint: always compares the incoming PC
      assign match = eq;
    end else begin : g_data
      assign match = ~ctl.vsens | eq;
    end
  endgenerate

  assign det     = ctl.armed & wr_acc & match;
  assign hit_nxt = det & ~hit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit_nxt;
  end

  assign hit = hit_q;

  // R10
  hit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit);

  // R9
  hit_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_acc |=> !hit);

  // R8
  hit_disarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.armed |=> !hit);

  generate
    if (KIND == dbgreg_pkg::BP_PROG) begin : g_prog_chk
      // R11
      pc_match_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.armed && wr_acc && wdata == cmp && !hit) |=> hit);
    end else begin : g_data_chk
      // R7
      value_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.vsens && wdata != cmp) |=> !hit);
    end
  endgenerate
endmodule

// File: rtl/dbg_reg_bp.sv
module dbg_reg_bp #(
  parameter int                   WIDTH = 32,
  parameter dbgreg_pkg::bp_kind_e KIND  = dbgreg_pkg::BP_DATA
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             fn_we,
  input  logic [WIDTH-1:0] fn_wdata,
  input  logic             dbg_we,
  input  logic [WIDTH-1:0] dbg_wdata,
  input  logic             cfg_we,
  input  logic             cfg_en,
  input  logic             cfg_vsens,
  input  logic [WIDTH-1:0] cfg_value,
  output logic [WIDTH-1:0] rd_data,
  output logic [WIDTH-1:0] dbg_rd_data,
  output logic             bp_hit
);
  logic                rst_n_s;
  logic                fn_acc;
  logic [WIDTH-1:0]    value;
  dbgreg_pkg::bp_ctl_t ctl;
  logic [WIDTH-1:0]    cmp;

  dbg_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  dbg_store #(.WIDTH(WIDTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .run_en    (run_en),
    .fn_we     (fn_we),
    .fn_wdata  (fn_wdata),
    .dbg_we    (dbg_we),
    .dbg_wdata (dbg_wdata),
    .fn_acc    (fn_acc),
    .value     (value)
  );

  dbg_bp_cfg #(.WIDTH(WIDTH)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .cfg_we    (cfg_we),
    .cfg_en    (cfg_en),
    .cfg_vsens (cfg_vsens),
    .cfg_value (cfg_value),
    .ctl       (ctl),
    .cmp       (cmp)
  );

  dbg_bp_detect #(.WIDTH(WIDTH), .KIND(KIND)) u_det (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .wr_acc (fn_acc),
    .wdata  (fn_wdata),
    .ctl    (ctl),
    .cmp    (cmp),
    .hit    (bp_hit)
  );

  assign rd_data     = value;
  assign dbg_rd_data = value;

  // R4
  dbg_priority_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (dbg_we && fn_we && run_en) |=> (rd_data == $past(dbg_wdata)));
endmodule

// File: tb/tb_dbg_reg_bp.sv
module tb_dbg_reg_bp;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         run_en, fn_we, dbg_we, cfg_we, cfg_en, cfg_vsens;
  logic [W-1:0] fn_wdata, dbg_wdata, cfg_value;
  logic [W-1:0] rd_d, drd_d, rd_p, drd_p;
  logic         hit_d, hit_p;

  int n_chk = 0;
  int n_bad = 0;

  // model state
  logic [W-1:0] m_val, m_cmp;
  logic         m_en, m_vs, m_hd, m_hp;

  always #10 clk = ~clk;

  dbg_reg_bp #(.WIDTH(W), .KIND(dbgreg_pkg::BP_DATA)) dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .fn_we(fn_we), .fn_wdata(fn_wdata),
    .dbg_we(dbg_we), .dbg_wdata(dbg_wdata), .cfg_we(cfg_we), .cfg_en(cfg_en),
    .cfg_vsens(cfg_vsens), .cfg_value(cfg_value),
    .rd_data(rd_d), .dbg_rd_data(drd_d), .bp_hit(hit_d));

  dbg_reg_bp #(.WIDTH(W), .KIND(dbgreg_pkg::BP_PROG)) dut_pc (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .fn_we(fn_we), .fn_wdata(fn_wdata),
    .dbg_we(dbg_we), .dbg_wdata(dbg_wdata), .cfg_we(cfg_we), .cfg_en(cfg_en),
    .cfg_vsens(cfg_vsens), .cfg_value(cfg_value),
    .rd_data(rd_p), .dbg_rd_data(drd_p), .bp_hit(hit_p));

  function automatic logic [W-1:0] nxt_val(logic [W-1:0] cur, logic r, logic fw,
                                           logic [W-1:0] fd, logic dw, logic [W-1:0] dd);
    if (dw)          return dd;
    else if (fw & r) return fd;
    else             return cur;
  endfunction

  function automatic logic det(logic prog, logic en, logic vs, logic [W-1:0] c,
                               logic r, logic fw, logic dw, logic [W-1:0] fd);
    logic acc;
    acc = fw & r & ~dw;
    if (prog) return en & acc & (fd == c);
    else      return en & acc & (~vs | (fd == c));
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic r, logic fw, logic [W-1:0] fd,
                      logic dw, logic [W-1:0] dd,
                      logic cw, logic ce, logic cv, logic [W-1:0] cval);
    logic dd_hit, dp_hit;
    @(negedge clk);
    run_en = r; fn_we = fw; fn_wdata = fd; dbg_we = dw; dbg_wdata = dd;
    cfg_we = cw; cfg_en = ce; cfg_vsens = cv; cfg_value = cval;
    dd_hit = det(1'b0, m_en, m_vs, m_cmp, r, fw, dw, fd) & ~m_hd;
    dp_hit = det(1'b1, m_en, m_vs, m_cmp, r, fw, dw, fd) & ~m_hp;
    m_hd   = dd_hit;
    m_hp   = dp_hit;
    m_val  = nxt_val(m_val, r, fw, fd, dw, dd);
    if (cw) begin m_en = ce; m_vs = cv; m_cmp = cval; end
    @(posedge clk);
    #5;
    check({tag, " R5 rd_data"},     rd_d,  m_val);
    check({tag, " R5 dbg_rd_data"}, drd_d, m_val);
    check({tag, " R5 pc rd_data"},  rd_p,  m_val);
    check({tag, " data bp_hit"},    hit_d, m_hd);
    check({tag, " R11 pc bp_hit"},  hit_p, m_hp);
  endtask

  initial begin : watchdog
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    run_en = 0; fn_we = 0; dbg_we = 0; cfg_we = 0; cfg_en = 0; cfg_vsens = 0;
    fn_wdata = '0; dbg_wdata = '0; cfg_value = '0;
    m_val = '0; m_cmp = '0; m_en = 0; m_vs = 0; m_hd = 0; m_hp = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rd_data",     rd_d,  '0);
    check("R1 dbg_rd_data", drd_d, '0);
    check("R1 bp_hit",      hit_d, 1'b0);
    check("R1 pc bp_hit",   hit_p, 1'b0);
    // R1 / R8: cleared config means disarmed; a write of 0 matches cmp 0 yet no hit
    step("R8 disarmed", 1, 1, 16'h0000, 0, 0, 0, 0, 0, 0);
    step("R8 disarmed", 1, 1, 16'h1234, 0, 0, 0, 0, 0, 0);
    // R12 arm any-write, cmp 0x55; takes effect next cycle
    step("R12 load",  1, 1, 16'h0055, 0, 0, 1, 1, 0, 16'h0055);
    step("R6 any",    1, 1, 16'h1234, 0, 0, 0, 0, 0, 0);
    step("R10 idle",  1, 0, 16'h0000, 0, 0, 0, 0, 0, 0);
    // R10 back-to-back writes: second detection dropped
    step("R10 a",     1, 1, 16'h0001, 0, 0, 0, 0, 0, 0);
    step("R10 b",     1, 1, 16'h0002, 0, 0, 0, 0, 0, 0);
    step("R10 c",     1, 1, 16'h0003, 0, 0, 0, 0, 0, 0);
    // R7 value-sensitive
    step("R12 vs",    1, 0, 16'h0000, 0, 0, 1, 1, 1, 16'h0055);
    step("R7 miss",   1, 1, 16'h1111, 0, 0, 0, 0, 0, 0);
    step("R7 idle",   1, 0, 16'h0000, 0, 0, 0, 0, 0, 0);
    step("R7 match",  1, 1, 16'h0055, 0, 0, 0, 0, 0, 0);
    step("R7 idle",   1, 0, 16'h0000, 0, 0, 0, 0, 0, 0);
    // R2 / R9 halted
    step("R2 halt",   0, 1, 16'h0055, 0, 0, 0, 0, 0, 0);
    step("R2 halt",   0, 1, 16'hBEEF, 0, 0, 0, 0, 0, 0);
    // R3 debug write while halted
    step("R3 dbgw",   0, 0, 16'h0000, 1, 16'hCAFE, 0, 0, 0, 0);
    // R4 / R9 priority, debug wins and no hit despite matching fn data
    step("R4 prio",   1, 1, 16'h0055, 1, 16'h7777, 0, 0, 0, 0);
    step("R4 idle",   1, 0, 16'h0000, 0, 0, 0, 0, 0, 0);
    // R11 pc flavour ignores vsens=0
    step("R11 cfg",   1, 0, 16'h0000, 0, 0, 1, 1, 0, 16'h0400);
    step("R11 miss",  1, 1, 16'h03FC, 0, 0, 0, 0, 0, 0);
    step("R11 idle",  1, 0, 16'h0000, 0, 0, 0, 0, 0, 0);
    step("R11 hit",   1, 1, 16'h0400, 0, 0, 0, 0, 0, 0);
    // R8 disarm via load
    step("R8 disarm", 1, 1, 16'h0400, 0, 0, 1, 0, 0, 16'h0400);
    step("R8 check",  1, 1, 16'h0400, 0, 0, 0, 0, 0, 0);
    // random mix R2 R3 R4 R6 R7 R9 R10 R11 R12
    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] fd, cv;
      cv = {12'h0, 4'($urandom_range(0, 3))};
      fd = ($urandom_range(0, 2) != 0) ? {12'h0, 4'($urandom_range(0, 3))} : 16'($urandom);
      step("rand", ($urandom_range(0, 4) != 0), 1'($urandom), fd,
           ($urandom_range(0, 7) == 0), 16'($urandom),
           ($urandom_range(0, 15) == 0), ($urandom_range(0, 3) != 0), 1'($urandom), cv);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule